// File: doc/BRIEF.md
# Asynchronous SCSI Handshake Byte Mover

This block moves bytes one at a time across an 8-bit SCSI data bus using the asynchronous REQ/ACK handshake. It acts as the target side of the bus. A transfer starts on a single-cycle `start` pulse, which also samples a byte count and a direction. When `dir_tx` is 1 (data-in phase), bytes arrive on a valid/ready stream and are sent to the host. When `dir_tx` is 0 (data-out phase), bytes are read from the host and come out on a one-cycle `rx_valid` stream. A sticky flag records any parity mismatch seen during a receive.

All bus pins are active-low. The block works internally in asserted logic and inverts at the pins. Every bus output comes from a register. ACK is resynchronised through a parameterised flop chain. The level input `bus_reset` stops a transfer at any waiting point, and also stops one before it starts. A transfer ends with a one-cycle `done` pulse, whether it completed or was aborted.

The controller is a state machine with these states:
- IDLE
- TX_WAIT: wait for a byte on the stream
- TX_SETUP: drive data for the setup time
- TX_REQ: REQ asserted, wait for ACK
- TX_RELEASE: data and REQ dropped, wait for ACK to clear
- RX_REQ: REQ asserted, wait for ACK
- RX_SETTLE: count the settle delay, then sample
- RX_RELEASE: REQ dropped, wait for ACK to clear
- DONE

Its transitions are:
- start: IDLE to TX_WAIT or RX_REQ, or to DONE for a zero count or an active reset
- byte accepted: TX_WAIT to TX_SETUP
- setup elapsed: TX_SETUP to TX_REQ
- ack seen: TX_REQ to TX_RELEASE, and RX_REQ to RX_SETTLE
- settle elapsed, sample taken: RX_SETTLE to RX_RELEASE
- ack cleared: TX_RELEASE to TX_WAIT or DONE, and RX_RELEASE to RX_REQ or DONE, depending on the remaining count
- abort: any active state to DONE
- finish: DONE to IDLE

Top module: `scsi_async_xfer`

## Requirements
- R1: While reset is applied, and after it is released, the bus is released (`req_n`=1, `db_oe`=0), and `busy`, `done`, `tx_ready`, `rx_valid` and `parity_err` are all 0. Whenever `busy` is 0, REQ is deasserted and the data bus is not driven.
- R2: A start with a count of zero produces a `done` pulse and never asserts REQ.
- R3: On a send, the byte is driven inverted on `db_out_n`, with `db_oe`=1, for at least SETUP_CYC clock cycles before `req_n` falls. Data and parity stay stable while REQ is asserted.
- R4: On a send, once ACK has been seen, REQ and the data drive are released in the same cycle. The next byte is not driven, and REQ is not asserted, while `ack_n` is still low.
- R5: On a receive, the byte present on the bus while ACK is asserted is sampled after SETTLE_CYC cycles and delivered inverted back to true sense. `rx_data` is delivered with a one-cycle `rx_valid` pulse for each byte.
- R6: On a receive, REQ is deasserted after the sample. REQ is never asserted while `ack_n` is low, and the data bus is never driven.
- R7: Parity is odd. In asserted sense, the 8 data bits plus DBP hold an odd number of ones whenever the block drives the bus.
- R8: A received byte whose parity is not odd sets `parity_err`. The flag stays set until the next receive transfer starts; a send transfer does not clear it.
- R9: A transfer of N bytes performs exactly N REQ/ACK handshakes. It then gives a `done` pulse exactly one cycle wide, and `busy` returns to 0.
- R10: When `bus_reset` is high in any active state, the next state is DONE and no further bytes move; the bus is released one cycle later. A start while `bus_reset` is high goes directly to DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled in IDLE) |
| dir_tx | input | 1 | 1 = send to host, 0 = receive from host |
| xfer_count | input | CNT_W | Number of bytes to move |
| bus_reset | input | 1 | Bus-reset flag; aborts the transfer |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Block takes `tx_data` this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| parity_err | output | 1 | Sticky receive parity error |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| db_out_n | output | 8 | Data bus drive value, active-low |
| dbp_out_n | output | 1 | Parity drive value, active-low |
| db_oe | output | 1 | Data and parity output enable |
| req_n | output | 1 | REQ, active-low |
| db_in_n | input | 8 | Data bus sense, active-low |
| dbp_in_n | input | 1 | Parity sense, active-low |
| ack_n | input | 1 | ACK from host, active-low |

## Verification
The bench acts as a host that answers REQ with varying delays, and it checks every bus rule on every clock. It covers several cases:
- **Send setup time.** It counts how long each byte is held before REQ. A design that shortened the setup would assert REQ over unsettled data.
- **Receive sampling.** The host shows garbage until the moment it asserts ACK. A design that sampled before ACK, or after letting go of REQ, would deliver the wrong byte.
- **Parity flag lifetime.** It tracks the flag across a bad receive, a following send, and a later clean receive. A flag that cleared on every transfer, or never cleared, would show the wrong value after one of them.
- **Abort.** The host stalls mid-transfer and then `bus_reset` rises. Separately, `bus_reset` is already high at start. A design that kept waiting for ACK would hang or move extra bytes.

// File: rtl/scsi_xfer_pkg.sv
package scsi_xfer_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TX_WAIT,
        ST_TX_SETUP,
        ST_TX_REQ,
        ST_TX_RELEASE,
        ST_RX_REQ,
        ST_RX_SETTLE,
        ST_RX_RELEASE,
        ST_DONE
    } xfer_state_t;

    // Parity bit that makes data plus parity hold an odd count of ones
    function automatic logic odd_par_bit(input logic [7:0] d);
        return ~(^d);
    endfunction

    // True when data plus parity hold an odd count of ones
    function automatic logic odd_par_ok(input logic [7:0] d, input logic p);
        return ^{d, p};
    endfunction

endpackage

// File: rtl/scsi_xfer_sync.sv
module scsi_xfer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scsi_xfer_timer.sv
module scsi_xfer_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/scsi_xfer_fsm.sv
module scsi_xfer_fsm
    import scsi_xfer_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SETUP_CYC  = 10,
    parameter int SETTLE_CYC = 10,
    parameter int TMR_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_tx,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             bus_reset,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic             ack,
    input  logic [7:0]       bus_data,
    input  logic             bus_par,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             parity_err,
    output logic             busy,
    output logic             done,
    output logic [7:0]       drv_data,
    output logic             drv_par,
    output logic             drv_oe,
    output logic             drv_req,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    input  logic             tmr_expired
);
    localparam logic [TMR_W-1:0] SETUP_LOAD  = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] SETTLE_LOAD = TMR_W'(SETTLE_CYC - 1);

    xfer_state_t state, state_nx;
    logic [CNT_W-1:0] remaining;
    logic [7:0]       tx_byte;
    logic             last_byte;
    logic             byte_end;
    logic             rx_take;

    assign last_byte = (remaining == CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) begin
                if (bus_reset || xfer_count == '0) state_nx = ST_DONE;
                else if (dir_tx)                   state_nx = ST_TX_WAIT;
                else                               state_nx = ST_RX_REQ;
            end
            ST_TX_WAIT:    if (bus_reset) state_nx = ST_DONE;
                           else if (tx_valid) state_nx = ST_TX_SETUP;
            ST_TX_SETUP:   if (bus_reset) state_nx = ST_DONE;
                           else if (tmr_expired) state_nx = ST_TX_REQ;
            ST_TX_REQ:     if (bus_reset) state_nx = ST_DONE;
                           else if (ack) state_nx = ST_TX_RELEASE;
            ST_TX_RELEASE: if (bus_reset) state_nx = ST_DONE;
                           else if (!ack) state_nx = last_byte ? ST_DONE : ST_TX_WAIT;
            ST_RX_REQ:     if (bus_reset) state_nx = ST_DONE;
                           else if (ack) state_nx = ST_RX_SETTLE;
            ST_RX_SETTLE:  if (bus_reset) state_nx = ST_DONE;
                           else if (tmr_expired) state_nx = ST_RX_RELEASE;
            ST_RX_RELEASE: if (bus_reset) state_nx = ST_DONE;
                           else if (!ack) state_nx = last_byte ? ST_DONE : ST_RX_REQ;
            ST_DONE:       state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_ready = 1'b0;
        drv_oe   = 1'b0;
        drv_req  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = SETUP_LOAD;
        byte_end = 1'b0;
        rx_take  = 1'b0;
        unique case (state)
            ST_TX_WAIT: begin
                tx_ready = !bus_reset;
                tmr_load = tx_valid && !bus_reset;
            end
            ST_TX_SETUP:   drv_oe = 1'b1;
            ST_TX_REQ: begin
                drv_oe  = 1'b1;
                drv_req = 1'b1;
            end
            ST_TX_RELEASE: byte_end = !bus_reset && !ack;
            ST_RX_REQ: begin
                drv_req  = 1'b1;
                tmr_load = ack && !bus_reset;
                tmr_val  = SETTLE_LOAD;
            end
            ST_RX_SETTLE: begin
                drv_req = 1'b1;
                rx_take = tmr_expired && !bus_reset;
            end
            ST_RX_RELEASE: byte_end = !bus_reset && !ack;
            default: ;
        endcase
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        drv_data = tx_byte;
        drv_par  = odd_par_bit(tx_byte);
    end

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining  <= '0;
            tx_byte    <= '0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (state == ST_IDLE && start) begin
                remaining <= xfer_count;
                if (!dir_tx) parity_err <= 1'b0;
            end
            if (tx_ready && tx_valid) tx_byte <= tx_data;
            if (rx_take) begin
                rx_data  <= bus_data;
                rx_valid <= 1'b1;
                if (!odd_par_ok(bus_data, bus_par)) parity_err <= 1'b1;
            end
            if (byte_end) remaining <= remaining - 1'b1;
        end
    end
endmodule

// File: rtl/scsi_async_xfer.sv
module scsi_async_xfer #(
    parameter int CNT_W       = 16,
    parameter int SETUP_CYC   = 10,
    parameter int SETTLE_CYC  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_tx,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             bus_reset,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             parity_err,
    output logic             busy,
    output logic             done,
    output logic [7:0]       db_out_n,
    output logic             dbp_out_n,
    output logic             db_oe,
    output logic             req_n,
    input  logic [7:0]       db_in_n,
    input  logic             dbp_in_n,
    input  logic             ack_n
);
    localparam int TMR_MAX = (SETUP_CYC > SETTLE_CYC) ? SETUP_CYC : SETTLE_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    logic             ack_s;
    logic             tmr_load, tmr_expired;
    logic [TMR_W-1:0] tmr_val;
    logic [7:0]       drv_data;
    logic             drv_par, drv_oe, drv_req;

    scsi_xfer_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(~ack_n), .q(ack_s)
    );

    scsi_xfer_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_expired)
    );

    scsi_xfer_fsm #(
        .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .SETTLE_CYC(SETTLE_CYC), .TMR_W(TMR_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_tx(dir_tx),
        .xfer_count(xfer_count), .bus_reset(bus_reset),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .ack(ack_s), .bus_data(~db_in_n), .bus_par(~dbp_in_n),
        .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err),
        .busy(busy), .done(done),
        .drv_data(drv_data), .drv_par(drv_par), .drv_oe(drv_oe), .drv_req(drv_req),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_expired(tmr_expired)
    );

    // registered, inverted bus pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_n     <= 1'b1;
            db_oe     <= 1'b0;
            db_out_n  <= '1;
            dbp_out_n <= 1'b1;
        end else begin
            req_n     <= ~drv_req;
            db_oe     <= drv_oe;
            db_out_n  <= drv_oe ? ~drv_data : 8'hFF;
            dbp_out_n <= drv_oe ? ~drv_par  : 1'b1;
        end
    end
endmodule

// File: rtl/scsi_async_xfer_chk.sv
module scsi_async_xfer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_n,
    input logic       db_oe,
    input logic [7:0] db_out_n,
    input logic       dbp_out_n,
    input logic       busy,
    input logic       done,
    input logic       rx_valid,
    input logic       bus_reset
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (req_n && !db_oe)); // R1

    AST_DATA_STABLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && $past(!req_n) && db_oe) |-> ($stable(db_out_n) && $stable(dbp_out_n))); // R3

    AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_n) && $past(db_oe)) |-> !db_oe); // R4

    AST_RX_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R5

    AST_ODD_PARITY_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        db_oe |-> (^{~db_out_n, ~dbp_out_n}) == 1'b1); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && busy && !done) |=> done); // R10
endmodule

bind scsi_async_xfer scsi_async_xfer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .db_oe(db_oe), .db_out_n(db_out_n),
    .dbp_out_n(dbp_out_n), .busy(busy), .done(done), .rx_valid(rx_valid),
    .bus_reset(bus_reset)
);

// File: tb/scsi_async_xfer_test.sv
module scsi_async_xfer_test;
    localparam int CNT_W = 16;
    localparam int SETUP = 10;
    localparam int SETTLE = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, dir_tx = 1'b0, bus_reset = 1'b0;
    logic [CNT_W-1:0] xfer_count = '0;
    logic [7:0] tx_data = '0;
    logic tx_valid = 1'b0;
    logic tx_ready, rx_valid, parity_err, busy, done, dbp_out_n, db_oe, req_n;
    logic [7:0] rx_data, db_out_n;
    logic [7:0] db_in_n = 8'hFF;
    logic dbp_in_n = 1'b1, ack_n = 1'b1;

    int vectors = 0, fails = 0;

    always #5 clk = ~clk;

    scsi_async_xfer #(.CNT_W(CNT_W), .SETUP_CYC(SETUP), .SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_tx(dir_tx), .xfer_count(xfer_count),
        .bus_reset(bus_reset), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err), .busy(busy),
        .done(done), .db_out_n(db_out_n), .dbp_out_n(dbp_out_n), .db_oe(db_oe),
        .req_n(req_n), .db_in_n(db_in_n), .dbp_in_n(dbp_in_n), .ack_n(ack_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // reference queues
    logic [7:0] tx_src[$];
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];
    logic [8:0] host_q[$];
    bit cur_tx = 1'b1;

    // stream source
    bit tx_adv = 1'b0;
    always @(negedge clk) begin
        if (tx_adv && tx_src.size() > 0) exp_tx.push_back(tx_src.pop_front());
        tx_adv = tx_valid && tx_ready;
        tx_valid = (tx_src.size() > 0);
        if (tx_src.size() > 0) tx_data = tx_src[0];
    end

    // host responder
    int host_dly = 2, host_limit = 1000000, acks = 0, hcnt = 0;
    logic [8:0] hv;
    always @(negedge clk) begin
        if (!rst_n) hcnt = 0;
        else if (!req_n && ack_n) begin
            if (acks < host_limit) begin
                hcnt++;
                if (hcnt >= host_dly) begin
                    hcnt = 0;
                    acks++;
                    ack_n <= 1'b0;
                    if (!cur_tx && host_q.size() > 0) begin
                        hv = host_q.pop_front();
                        db_in_n  <= ~hv[7:0];
                        dbp_in_n <= ~hv[8];
                    end
                end
            end
        end else if (req_n && !ack_n) begin
            hcnt++;
            if (hcnt >= host_dly) begin
                hcnt = 0;
                ack_n   <= 1'b1;
                db_in_n <= ~db_in_n;
            end
        end
    end

    // cycle-by-cycle bus monitor
    int oe_run = 0, req_cnt = 0;
    logic prev_req_n = 1'b1, prev_oe = 1'b0;
    logic [7:0] prev_db = 8'hFF;
    logic [7:0] ev;
    always @(negedge clk) begin
        if (rst_n) begin
            if (db_oe && req_n)
                oe_run = (prev_oe && db_out_n == prev_db) ? oe_run + 1 : 1;
            if (!req_n && prev_req_n) begin
                req_cnt++;
                if (cur_tx) begin
                    check(ack_n == 1'b1, "R4 REQ while ACK low", int'(ack_n), 1);
                    check(oe_run >= SETUP, "R3 data setup before REQ", oe_run, SETUP);
                    if (exp_tx.size() > 0) begin
                        ev = exp_tx.pop_front();
                        check(~db_out_n == ev, "R3 driven byte", int'(~db_out_n), int'(ev));
                    end else check(1'b0, "R3 unexpected REQ", 1, 0);
                    check((^{~db_out_n, ~dbp_out_n}) == 1'b1, "R7 odd parity on send",
                          int'(~dbp_out_n), int'(~(^(~db_out_n))));
                end else begin
                    check(ack_n == 1'b1, "R6 REQ while ACK low", int'(ack_n), 1);
                    check(!db_oe, "R6 bus driven on receive", int'(db_oe), 0);
                end
            end
            if (cur_tx && req_n && !prev_req_n)
                check(!db_oe, "R4 data release with REQ", int'(db_oe), 0);
            if (cur_tx && !db_oe && prev_oe)
                check(req_n, "R4 REQ release with data", int'(req_n), 1);
            if (db_oe && !prev_oe)
                check(ack_n == 1'b1, "R4 next byte before ACK clear", int'(ack_n), 1);
            if (rx_valid) begin
                if (exp_rx.size() > 0) begin
                    ev = exp_rx.pop_front();
                    check(rx_data == ev, "R5 received byte", int'(rx_data), int'(ev));
                end else check(1'b0, "R5 unexpected rx_valid", 1, 0);
            end
            prev_req_n = req_n;
            prev_oe    = db_oe;
            prev_db    = db_out_n;
        end
    end

    task automatic wait_done();
        int t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(done, "R9 done arrives", int'(done), 1);
        @(negedge clk);
        check(!done, "R9 done one cycle wide", int'(done), 0);
        check(!busy, "R9 busy clears", int'(busy), 0);
        check(req_n && !db_oe, "R1 bus released when idle", int'({req_n, db_oe}), 2);
    endtask

    task automatic kick(input bit tx, input int n);
        @(negedge clk);
        cur_tx = tx;
        dir_tx = tx;
        xfer_count = CNT_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic logic [8:0] hbyte(input logic [7:0] d, input bit good);
        return {good ? ~(^d) : (^d), d};
    endfunction

    int a0, r0, t;

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(req_n && !db_oe && !busy && !done, "R1 bus released in reset", int'({req_n, db_oe, busy, done}), 8);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tx_ready && !rx_valid && !parity_err, "R1 outputs idle after reset",
              int'({tx_ready, rx_valid, parity_err}), 0);

        // R2 zero count
        r0 = req_cnt;
        kick(1'b1, 0);
        wait_done();
        check(req_cnt == r0, "R2 no REQ on zero count", req_cnt - r0, 0);

        // R3 R4 R7 R9 send of four bytes
        host_dly = 3;
        tx_src = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
        a0 = acks; r0 = req_cnt;
        kick(1'b1, 4);
        wait_done();
        check(acks - a0 == 4, "R9 send handshakes", acks - a0, 4);
        check(req_cnt - r0 == 4, "R9 send REQ count", req_cnt - r0, 4);
        check(exp_tx.size() == 0 && tx_src.size() == 0, "R9 all bytes sent", exp_tx.size(), 0);

        // R5 R6 R8 receive of three good bytes
        host_dly = 4;
        host_q = '{hbyte(8'h5A, 1), hbyte(8'h01, 1), hbyte(8'hFE, 1)};
        exp_rx = '{8'h5A, 8'h01, 8'hFE};
        a0 = acks;
        kick(1'b0, 3);
        wait_done();
        check(exp_rx.size() == 0, "R5 all bytes received", exp_rx.size(), 0);
        check(acks - a0 == 3, "R9 receive handshakes", acks - a0, 3);
        check(!parity_err, "R8 no error on good parity", int'(parity_err), 0);

        // R8 bad parity on second byte
        host_dly = 1;
        host_q = '{hbyte(8'h77, 1), hbyte(8'h80, 0)};
        exp_rx = '{8'h77, 8'h80};
        kick(1'b0, 2);
        wait_done();
        check(parity_err, "R8 error flag set", int'(parity_err), 1);

        // R8 send leaves the flag alone; R7 on another pattern
        tx_src = '{8'h81};
        kick(1'b1, 1);
        wait_done();
        check(parity_err, "R8 flag kept across send", int'(parity_err), 1);

        // R8 cleared at next receive start
        host_q = '{hbyte(8'hC3, 1)};
        exp_rx = '{8'hC3};
        kick(1'b0, 1);
        wait_done();
        check(!parity_err, "R8 flag cleared by receive", int'(parity_err), 0);

        // R10 abort during a stalled send
        host_dly = 2;
        a0 = acks;
        host_limit = acks + 2;
        tx_src = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        kick(1'b1, 5);
        repeat (80) @(negedge clk);
        check(!done && !req_n, "R10 stalled waiting for ACK", int'({done, req_n}), 0);
        bus_reset = 1'b1;
        t = 0;
        while (!done && t < 20) begin
            @(negedge clk);
            t++;
        end
        check(t <= 1, "R10 abort latency", t, 1);
        bus_reset = 1'b0;
        @(negedge clk);
        check(req_n && !db_oe, "R10 bus released after abort", int'({req_n, db_oe}), 2);
        check(acks - a0 == 2, "R10 no further bytes", acks - a0, 2);
        tx_src.delete();
        exp_tx.delete();
        host_limit = 1000000;

        // R10 abort during a receive REQ wait
        a0 = acks;
        host_limit = acks;
        host_q = '{hbyte(8'h99, 1)};
        kick(1'b0, 2);
        repeat (20) @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        check(done, "R10 receive abort", int'(done), 1);
        bus_reset = 1'b0;
        @(negedge clk);
        check(req_n && !busy, "R10 receive abort released", int'({req_n, busy}), 2);
        check(acks == a0 && exp_rx.size() == 0, "R10 nothing received", acks - a0, 0);
        host_q.delete();
        host_limit = 1000000;

        // R10 start while bus reset active
        bus_reset = 1'b1;
        r0 = req_cnt;
        kick(1'b1, 3);
        wait_done();
        check(req_cnt == r0, "R10 start under reset moves nothing", req_cnt - r0, 0);
        bus_reset = 1'b0;

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog expired: actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule